// File: doc/BRIEF.md
# Configurable PLD Output Macrocell

This block is one output cell of a small programmable logic device. It takes two groups of product terms, already formed by the AND-OR array outside the block. It ORs each group. The main sum passes through a polarity inverter controlled by a configuration bit. The result either goes straight to the output (bypass mode) or is stored in a register. Configuration makes that register behave as a D, T, JK or SR flip-flop. In JK and SR modes the auxiliary sum supplies the K or R input. The single cell value drives three identical outputs at once: the pin path, the bus read path and the feedback path into the array.

The register has level-sensitive, active-high preset and clear lines, and each comes from its own product term. Its clock is either a product-term clock or a clock shared by all cells, and each cell selects its source by configuration. The selected clock is not used as a real clock. It is sampled on the free-running system clock through a two-stage synchronizer, and a low-to-high change of the sampled value enables one register update. Configuration inputs are expected to stay static while the cell runs. A device would place 16 of these cells side by side, each configured on its own.

Top module: `pld_macrocell`

## Requirements
- R1: In bypass mode (`cfg_bypass_i`=1), every output equals the OR of `pt_main_i` XOR `cfg_invert_i`, with no clock delay.
- R2: `cfg_kind_i` selects the register type: 2'b00 D (q takes the polarity-adjusted main sum), 2'b01 T (q toggles when that sum is 1), 2'b10 JK, 2'b11 SR. In JK and SR, J/S is the polarity-adjusted main sum and K/R is the OR of `pt_aux_i`. For JK and SR, input 10 sets q and input 01 clears it.
- R3: In JK mode J=K=1 toggles q. In SR mode S=R=1 leaves q unchanged. Inputs 00 hold q in both modes.
- R4: While `pt_clear_i` is high, q is 0 from the next system clock edge on. While `pt_preset_i` is high and clear is low, q is 1. Clear wins when both are high, and either one overrides a clock event.
- R5: The register changes only on a rising edge of the selected clock source. After the source rises, the new value appears after the third rising edge of `clk_i`. A falling edge of the source, or a steady source, leaves q unchanged.
- R6: With `cfg_common_clk_i`=1, q is clocked by `common_clk_i` and `pt_clk_i` has no effect. With 0, the roles swap.
- R7: In registered mode (`cfg_bypass_i`=0), the outputs show q and do not follow changes on the product-term inputs between clock events.
- R8: `pin_o`, `bus_o` and `fb_o` always carry the same value.
- R9: After reset q is 0. Reset asserts asynchronously and releases two `clk_i` edges after `rst_ni` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_kind_i | input | 2 | Register type: 00 D, 01 T, 10 JK, 11 SR |
| cfg_invert_i | input | 1 | 1 inverts the main sum |
| cfg_common_clk_i | input | 1 | 1 selects the shared clock, 0 the product-term clock |
| cfg_bypass_i | input | 1 | 1 routes the combinational value to the outputs |
| pt_main_i | input | NUM_PT | Main product terms (D/T/J/S) |
| pt_aux_i | input | NUM_PT | Auxiliary product terms (K/R) |
| pt_clk_i | input | 1 | Product-term clock |
| pt_preset_i | input | 1 | Product-term preset, active high |
| pt_clear_i | input | 1 | Product-term clear, active high |
| common_clk_i | input | 1 | Shared clock for all cells |
| pin_o | output | 1 | Cell value toward the pin allocator |
| bus_o | output | 1 | Cell value toward the bus read path |
| fb_o | output | 1 | Cell value fed back to the array |

## Verification
The assertions watch, on every cycle, the behaviours that can be stated locally. A clock event lasts one cycle. The register holds when no event, preset or clear is present. Clear beats preset. D-mode capture follows the main sum. The bench sweeps every register type, polarity, starting state, input pair and clock source. These sweeps are the only evidence for the T, JK and SR next-state tables, the three-cycle latency from a source edge, the falling-edge and unselected-source immunity, and the full bypass truth table over all product-term patterns.

// File: rtl/mc_pkg.sv
package mc_pkg;
  typedef enum logic [1:0] {
    KIND_D  = 2'b00,
    KIND_T  = 2'b01,
    KIND_JK = 2'b10,
    KIND_SR = 2'b11
  } ff_kind_e;
endpackage

// File: rtl/mc_sop_polarity.sv
module mc_sop_polarity #(
  parameter int NUM_PT = 8
) (
  input  logic [NUM_PT-1:0] terms_i,
  input  logic              invert_i,
  output logic              sum_o
);
  logic or_sum;

  always_comb begin
    or_sum = |terms_i;
    sum_o  = or_sum ^ invert_i;
  end
endmodule

// File: rtl/mc_clk_edge.sv
module mc_clk_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic use_common_i,
  input  logic pt_clk_i,
  input  logic common_clk_i,
  output logic rise_o
);
  logic                   src;
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;

  always_comb begin
    src    = use_common_i ? common_clk_i : pt_clk_i;
    sync_d = {sync_q[SYNC_STAGES-2:0], src};
    prev_d = sync_q[SYNC_STAGES-1];
    rise_o = sync_q[SYNC_STAGES-1] & ~prev_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  // R5: one source rise produces exactly one single-cycle event
  assert_single_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/mc_store.sv
module mc_store
  import mc_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  ff_kind_e kind_i,
  input  logic     en_i,
  input  logic     main_i,
  input  logic     aux_i,
  input  logic     preset_i,
  input  logic     clear_i,
  output logic     q_o
);
  logic q_q, q_d, clk_en, ff_next;

  always_comb begin
    ff_next = q_q;
    unique case (kind_i)
      KIND_D:  ff_next = main_i;
      KIND_T:  ff_next = q_q ^ main_i;
      KIND_JK: begin
        unique case ({main_i, aux_i})
          2'b00:   ff_next = q_q;
          2'b01:   ff_next = 1'b0;
          2'b10:   ff_next = 1'b1;
          default: ff_next = ~q_q;
        endcase
      end
      default: begin
        unique case ({main_i, aux_i})
          2'b01:   ff_next = 1'b0;
          2'b10:   ff_next = 1'b1;
          default: ff_next = q_q;
        endcase
      end
    endcase

    clk_en = en_i | preset_i | clear_i;
    if (clear_i)       q_d = 1'b0;
    else if (preset_i) q_d = 1'b1;
    else               q_d = ff_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_q <= 1'b0;
    else if (clk_en) q_q <= q_d;
  end

  assign q_o = q_q;

  assert_clear_wins_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !q_q);
  assert_preset_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (preset_i && !clear_i) |=> q_q);
  assert_hold_no_event_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !preset_i && !clear_i) |=> $stable(q_q));
  assert_d_capture_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !preset_i && !clear_i && kind_i == KIND_D) |=> (q_q == $past(main_i)));
endmodule

// File: rtl/pld_macrocell.sv
module pld_macrocell
  import mc_pkg::*;
#(
  parameter int NUM_PT      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cfg_kind_i,
  input  logic              cfg_invert_i,
  input  logic              cfg_common_clk_i,
  input  logic              cfg_bypass_i,
  input  logic [NUM_PT-1:0] pt_main_i,
  input  logic [NUM_PT-1:0] pt_aux_i,
  input  logic              pt_clk_i,
  input  logic              pt_preset_i,
  input  logic              pt_clear_i,
  input  logic              common_clk_i,
  output logic              pin_o,
  output logic              bus_o,
  output logic              fb_o
);
  localparam int RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_sync_q;
  logic                  rst_int_n;
  logic                  main_sum, aux_sum, clk_rise, q, cell_val;
  ff_kind_e              kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[RST_STAGES-1];

  assign kind = ff_kind_e'(cfg_kind_i);

  mc_sop_polarity #(.NUM_PT(NUM_PT)) u_main (
    .terms_i (pt_main_i),
    .invert_i(cfg_invert_i),
    .sum_o   (main_sum)
  );

  mc_sop_polarity #(.NUM_PT(NUM_PT)) u_aux (
    .terms_i (pt_aux_i),
    .invert_i(1'b0),
    .sum_o   (aux_sum)
  );

  mc_clk_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_int_n),
    .use_common_i(cfg_common_clk_i),
    .pt_clk_i    (pt_clk_i),
    .common_clk_i(common_clk_i),
    .rise_o      (clk_rise)
  );

  mc_store u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .kind_i  (kind),
    .en_i    (clk_rise),
    .main_i  (main_sum),
    .aux_i   (aux_sum),
    .preset_i(pt_preset_i),
    .clear_i (pt_clear_i),
    .q_o     (q)
  );

  assign cell_val = cfg_bypass_i ? main_sum : q;
  assign pin_o    = cell_val;
  assign bus_o    = cell_val;
  assign fb_o     = cell_val;

  // R9: the register is cleared while internal reset is held
  assert_reset_clear_R9: assert property (@(posedge clk_i)
    (!rst_int_n && !cfg_bypass_i) |-> !pin_o);
endmodule

// File: tb/sim_pld_macrocell.sv
`timescale 1ns/1ps
module sim_pld_macrocell;
  localparam int NPT = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] kind = 2'b00;
  logic inv = 1'b0, use_common = 1'b0, bypass = 1'b0;
  logic [NPT-1:0] pmain = '0, paux = '0;
  logic pclk = 1'b0, ppre = 1'b0, pclr = 1'b0, cclk = 1'b0;
  logic pin, bus, fb;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pld_macrocell #(.NUM_PT(NPT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_kind_i(kind), .cfg_invert_i(inv),
    .cfg_common_clk_i(use_common), .cfg_bypass_i(bypass),
    .pt_main_i(pmain), .pt_aux_i(paux), .pt_clk_i(pclk),
    .pt_preset_i(ppre), .pt_clear_i(pclr), .common_clk_i(cclk),
    .pin_o(pin), .bus_o(bus), .fb_o(fb)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_same();
    checks++;
    if (!(pin === bus && bus === fb)) begin
      errors++;
      $display("FAIL R8: actual pin/bus/fb %b%b%b expected all equal", pin, bus, fb);
    end
  endtask

  task automatic force_q(input logic v);
    @(negedge clk);
    pclr = ~v; ppre = v;
    @(negedge clk);
    pclr = 1'b0; ppre = 1'b0;
  endtask

  task automatic drive_src(input logic sel_common, input logic v);
    @(negedge clk);
    if (sel_common) cclk = v; else pclk = v;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic model(input int k, input logic q0, input logic a, input logic b);
    case (k)
      0: return a;
      1: return q0 ^ a;
      2: return (a && b) ? ~q0 : (a ? 1'b1 : (b ? 1'b0 : q0));
      default: return (a && !b) ? 1'b1 : ((!a && b) ? 1'b0 : q0);
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk("R9", pin, 1'b0);
    chk_same();

    // R1, R8 full bypass sweep
    bypass = 1'b1;
    for (int iv = 0; iv < 2; iv++) begin
      for (int m = 0; m < (1 << NPT); m++) begin
        @(negedge clk);
        inv = iv[0]; pmain = m[NPT-1:0];
        #1;
        chk("R1", pin, (m != 0) ^ iv[0]);
        chk_same();
      end
    end
    bypass = 1'b0; inv = 1'b0; pmain = '0;

    // R2 R3 R5 R6 R7 sequential sweep
    for (int k = 0; k < 4; k++)
      for (int iv = 0; iv < 2; iv++)
        for (int q0 = 0; q0 < 2; q0++)
          for (int a = 0; a < 2; a++)
            for (int b = 0; b < 2; b++)
              for (int cs = 0; cs < 2; cs++) begin
                logic exp;
                kind = k[1:0]; inv = iv[0]; use_common = cs[0];
                force_q(q0[0]);
                chk("R4", pin, q0[0]);
                @(negedge clk);
                pmain = (a[0] ^ iv[0]) ? NPT'(1) << ((k + b) % NPT) : '0;
                paux  = b[0] ? NPT'(1) << ((k + a) % NPT) : '0;
                #1;
                chk("R7", pin, q0[0]);
                // R6: unselected source toggles without effect
                drive_src(~cs[0], 1'b1);
                drive_src(~cs[0], 1'b0);
                chk("R6", pin, q0[0]);
                exp = model(k, q0[0], a[0], b[0]);
                // R5: three clk edges after the rise
                @(negedge clk);
                if (cs[0]) cclk = 1'b1; else pclk = 1'b1;
                repeat (2) @(posedge clk);
                @(negedge clk);
                chk("R5", pin, q0[0]);
                @(posedge clk); @(negedge clk);
                chk((k >= 2) ? "R3" : "R2", pin, exp);
                chk_same();
                drive_src(cs[0], 1'b0);
                chk("R5", pin, exp);
                pmain = '0; paux = '0;
              end

    // R4 clear over preset, both over a clock event
    kind = 2'b00; inv = 1'b1; use_common = 1'b0;
    force_q(1'b1);
    @(negedge clk); ppre = 1'b1; pclr = 1'b1;
    @(negedge clk);
    chk("R4", pin, 1'b0);
    ppre = 1'b0;
    pclk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4", pin, 1'b0);
    pclr = 1'b0; pclk = 1'b0;
    repeat (4) @(negedge clk);
    ppre = 1'b1; inv = 1'b0; pclk = 1'b1;
    repeat (4) @(negedge clk);
    chk("R4", pin, 1'b1);
    ppre = 1'b0; pclk = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule